// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot capability, slot control and slot status state of a downstream port whose slot accepts hot-pluggable devices. Software reaches it through a single-cycle register port with 32-bit data and per-byte write enables. Reads are combinational. Word 0 is the read-only slot capability. Word 1 carries slot control in bytes 0–1 and slot status in bytes 2–3. Hardware event inputs report attention-button presses, power faults, link-state changes and hot-add requests. The block reports refused hot-adds and device removals on one-cycle outputs.

Event status bits are cleared by writing a one to them. Any write that reaches a control byte counts as one command, and that command completes at once. The block combines the enabled event bits with a master hot-plug interrupt enable into one notify condition. It signals that condition either as a level INTx line or, in message mode, as a one-cycle pulse when the condition rises.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, word 1 reads with all event enables (control bits 4:0) and the master enable (bit 5) at 0, the attention indicator (bits 7:6) at 2'b11 (off), and all event status bits (bits 20:16) at 0. Presence-detected (bit 21) equals `boot_present`, interlock-engaged (bit 22) is 0, and `intx` is low.
- R2: Word 0 reads the constant `{SLOT_NUM[12:0], 13'b0, 6'b111111}` with bit 1 equal to `PWR_CTRL`. Writes to word 0 change nothing and do not set command-completed.
- R3: Writing word 1 with byte enable 2 set clears each event status bit 16..20 whose data bit is 1. A write with byte enable 2 clear leaves the event bits unchanged.
- R4: Every word-1 write with byte enable 0 or byte enable 1 set sets command-completed (bit 19), whichever fields it changes.
- R5: The interlock-control bit (bit 11) always reads 0. A control write with byte enable 1 and bit 11 set toggles interlock-engaged (bit 22).
- R6: A control write with byte enable 1, power-off bit 10 set and power indicator bits 9:8 equal to 2'b11, made while presence is detected, does three things. It clears presence-detected, sets presence-changed (bit 18), and pulses `dev_detach` for one cycle.
- R7: A `hot_add_req` while interlock-engaged is set produces a one-cycle `hot_add_busy` and changes no state. Otherwise it sets presence-detected, presence-changed and attention-button (bit 16).
- R8: Let the notify condition be master enable AND any (status bits 20:16 AND enable bits 4:0). With `msi_mode` low, `intx` equals this condition, including falling after a status clear or an enable clear.
- R9: With `msi_mode` high, `intx` stays low and `msg_pulse` is high for exactly one cycle when the notify condition goes from 0 to 1. Setting an already-set event, or a further event while the condition holds, gives no pulse.
- R10: With `PWR_CTRL` set, reset leaves power-off (bit 10) at 0 and the power indicator (bits 9:8) at 2'b01 (on) when `boot_present` is high. Otherwise it leaves power-off at 1 and the indicator at 2'b11 (off).
- R11: `btn_press`, `pwr_fault` and `link_chg` set status bits 16, 17 and 20. An event set wins over a clear of the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_present | input | 1 | Device present at power-up, loaded during reset |
| msi_mode | input | 1 | 1 selects message pulse signalling, 0 selects INTx level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address (0 capability, 1 control/status) |
| reg_be | input | 4 | Byte write enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| btn_press | input | 1 | Attention button event |
| pwr_fault | input | 1 | Power fault event |
| link_chg | input | 1 | Link-state change event |
| hot_add_req | input | 1 | Request to add a device to the slot |
| hot_add_busy | output | 1 | Hot-add refused, interlock engaged |
| dev_detach | output | 1 | Device removal carried out |
| intx | output | 1 | Level interrupt |
| msg_pulse | output | 1 | One-cycle message interrupt request |

## Verification
A wrong status or enable bit shows up on a word-1 read in the cycle after the edge that stored it. It also reaches `intx` or `msg_pulse` in that same cycle, because both outputs are formed straight from the stored bits. A stale copy of the previous notify condition shows as a missing pulse, a pulse that lasts two cycles, or a repeated pulse on an event that was already set. A mishandled interlock or presence bit shows at the next hot-add or removal handshake, as a wrong `hot_add_busy` or `dev_detach` one cycle after the request.

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl #(
  parameter int          ADDR_W   = 2,
  parameter bit          PWR_CTRL = 1'b1,
  parameter logic [12:0] SLOT_NUM = 13'd5,
  parameter int          EV_N     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_present,
  input  logic              msi_mode,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              btn_press,
  input  logic              pwr_fault,
  input  logic              link_chg,
  input  logic              hot_add_req,
  output logic              hot_add_busy,
  output logic              dev_detach,
  output logic              intx,
  output logic              msg_pulse
);
  localparam logic [ADDR_W-1:0] CAP_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] SC_ADDR  = ADDR_W'(1);
  localparam int STS_LSB = 16;
  localparam int EV_BTN = 0, EV_PF = 1, EV_PRES = 2, EV_CMD = 3, EV_LINK = 4;
  localparam logic [1:0] IND_ON = 2'b01, IND_OFF = 2'b11;
  localparam logic [31:0] CAP_WORD = {SLOT_NUM, 13'b0, 4'b1111, PWR_CTRL, 1'b1};

  logic [EV_N-1:0] en_q, ev_q, ev_set, ev_clr;
  logic       hp_ie_q, pwr_off_q, pres_q, ilock_q, notify_q, busy_q, detach_q;
  logic [1:0] attn_q, pwr_ind_q;
  logic       sc_sel, ctl_wr, lane0, lane1, sts_wr, detach, add_ok, notify;

  assign sc_sel = reg_wr && (reg_addr == SC_ADDR);
  assign ctl_wr = sc_sel && |reg_be[1:0];
  assign lane0  = sc_sel && reg_be[0];
  assign lane1  = sc_sel && reg_be[1];
  assign sts_wr = sc_sel && reg_be[2];

  assign detach = lane1 && pres_q && reg_wdata[10] && (reg_wdata[9:8] == IND_OFF);
  assign add_ok = hot_add_req && !ilock_q;

  always_comb begin
    ev_set          = '0;
    ev_set[EV_BTN]  = btn_press || add_ok;
    ev_set[EV_PF]   = pwr_fault;
    ev_set[EV_PRES] = detach || add_ok;
    ev_set[EV_CMD]  = ctl_wr;
    ev_set[EV_LINK] = link_chg;
    ev_clr = sts_wr ? reg_wdata[STS_LSB +: EV_N] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      hp_ie_q   <= 1'b0;
      attn_q    <= IND_OFF;
      pwr_off_q <= PWR_CTRL ? !boot_present : 1'b0;
      pwr_ind_q <= (PWR_CTRL && boot_present) ? IND_ON : IND_OFF;
      ev_q      <= '0;
      pres_q    <= boot_present;
      ilock_q   <= 1'b0;
      notify_q  <= 1'b0;
      busy_q    <= 1'b0;
      detach_q  <= 1'b0;
    end else begin
      if (lane0) begin
        en_q    <= reg_wdata[EV_N-1:0];
        hp_ie_q <= reg_wdata[5];
        attn_q  <= reg_wdata[7:6];
      end
      if (lane1) begin
        pwr_ind_q <= reg_wdata[9:8];
        if (PWR_CTRL) pwr_off_q <= reg_wdata[10];
        if (reg_wdata[11]) ilock_q <= !ilock_q;
      end
      ev_q <= (ev_q & ~ev_clr) | ev_set;
      if (add_ok)      pres_q <= 1'b1;
      else if (detach) pres_q <= 1'b0;
      notify_q <= notify;
      busy_q   <= hot_add_req && ilock_q;
      detach_q <= detach;
    end
  end

  assign notify       = hp_ie_q && |(ev_q & en_q);
  assign intx         = !msi_mode && notify;
  assign msg_pulse    = msi_mode && notify && !notify_q;
  assign hot_add_busy = busy_q;
  assign dev_detach   = detach_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CAP_ADDR) reg_rdata = CAP_WORD;
    else if (reg_addr == SC_ADDR)
      reg_rdata = {9'b0, ilock_q, pres_q, ev_q, 4'b0, 1'b0, pwr_off_q,
                   pwr_ind_q, attn_q, hp_ie_q, en_q};
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[31:STS_LSB+EV_N], reg_wdata[15:12], reg_be[3]};
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk #(
  parameter int ADDR_W = 2,
  parameter int EV_N   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [3:0]        reg_be,
  input logic [31:0]       reg_wdata,
  input logic              btn_press,
  input logic              hot_add_req,
  input logic              hot_add_busy,
  input logic              dev_detach,
  input logic              msg_pulse,
  input logic [EV_N-1:0]   ev_q,
  input logic              pres_q,
  input logic              ilock_q
);
  localparam logic [ADDR_W-1:0] SC = ADDR_W'(1);

  a_r4_cmd_after_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SC && |reg_be[1:0]) |=> ev_q[3]);

  a_r3_w1c_clears_button: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SC && reg_be[2] && reg_wdata[16] && !btn_press && !hot_add_req)
    |=> !ev_q[0]);

  a_r7_busy_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_add_req && ilock_q) |=> hot_add_busy);

  a_r7_add_sets_presence: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_add_req && !ilock_q) |=> (pres_q && ev_q[2]));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse |=> !msg_pulse);

  a_r6_detach_single: assert property (@(posedge clk) disable iff (!rst_n)
    dev_detach |=> !dev_detach);
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(.ADDR_W(ADDR_W), .EV_N(EV_N)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
  .reg_wdata(reg_wdata), .btn_press(btn_press), .hot_add_req(hot_add_req),
  .hot_add_busy(hot_add_busy), .dev_detach(dev_detach), .msg_pulse(msg_pulse),
  .ev_q(ev_q), .pres_q(pres_q), .ilock_q(ilock_q));

// File: tb/test_hp_slot_ctrl.sv
`timescale 1ns/1ps
module test_hp_slot_ctrl;
  logic clk = 0, rst_n = 0, boot_present = 1, msi_mode = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [3:0] reg_be = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic btn_press = 0, pwr_fault = 0, link_chg = 0, hot_add_req = 0;
  logic hot_add_busy, dev_detach, intx, msg_pulse;
  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hp_slot_ctrl i_hp_slot_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_be = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a; #1; chk(tag, reg_rdata, exp);
  endtask

  task automatic do_reset(input logic present);
    @(negedge clk); rst_n = 0; boot_present = present;
    repeat (2) @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset_populated;
    rd_chk("R1 R10 reset word1 populated", 2'd1, 32'h002001C0);
    chk("R1 intx after reset", {31'b0, intx}, 0);
  endtask

  task automatic t_capability;
    rd_chk("R2 capability", 2'd0, 32'h0028003F);
    wr(2'd0, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R2 capability after write", 2'd0, 32'h0028003F);
    rd_chk("R2 no command from word0 write", 2'd1, 32'h002001C0);
  endtask

  task automatic t_command_w1c;
    wr(2'd1, 4'b0001, 32'h0000_00C0);
    rd_chk("R4 command completed on byte0 write", 2'd1, 32'h002801C0);
    wr(2'd1, 4'b1000, 32'h0008_0000);
    rd_chk("R3 clear ignored without byte2", 2'd1, 32'h002801C0);
    wr(2'd1, 4'b0100, 32'h0008_0000);
    rd_chk("R3 W1C clears command", 2'd1, 32'h002001C0);
  endtask

  task automatic t_interlock;
    wr(2'd1, 4'b0010, 32'h0000_0900);
    rd_chk("R5 interlock engaged, ctl bit reads 0", 2'd1, 32'h006801C0);
    @(negedge clk); hot_add_req = 1; @(negedge clk); hot_add_req = 0;
    chk("R7 busy pulse", {31'b0, hot_add_busy}, 1);
    rd_chk("R7 refused add leaves state", 2'd1, 32'h006801C0);
    @(negedge clk);
    chk("R7 busy single cycle", {31'b0, hot_add_busy}, 0);
    wr(2'd1, 4'b0010, 32'h0000_0900);
    rd_chk("R5 interlock toggled off", 2'd1, 32'h002801C0);
    wr(2'd1, 4'b0100, 32'h001F_0000);
  endtask

  task automatic t_detach_add;
    wr(2'd1, 4'b0010, 32'h0000_0700);
    chk("R6 detach pulse", {31'b0, dev_detach}, 1);
    rd_chk("R6 presence cleared, change set", 2'd1, 32'h000C07C0);
    @(negedge clk);
    chk("R6 detach single cycle", {31'b0, dev_detach}, 0);
    wr(2'd1, 4'b0100, 32'h001F_0000);
    rd_chk("R3 clear all events", 2'd1, 32'h000007C0);
    @(negedge clk); hot_add_req = 1; @(negedge clk); hot_add_req = 0;
    chk("R7 no busy when unlocked", {31'b0, hot_add_busy}, 0);
    rd_chk("R7 hot-add sets presence and events", 2'd1, 32'h002507C0);
    wr(2'd1, 4'b0100, 32'h001F_0000);
  endtask

  task automatic t_intx;
    wr(2'd1, 4'b0001, 32'h0000_00E1);
    chk("R8 disabled command event no intx", {31'b0, intx}, 0);
    wr(2'd1, 4'b0100, 32'h001F_0000);
    @(negedge clk); btn_press = 1; @(negedge clk); btn_press = 0;
    chk("R8 intx on enabled button", {31'b0, intx}, 1);
    @(negedge clk); pwr_fault = 1; @(negedge clk); pwr_fault = 0;
    rd_chk("R11 power fault status", 2'd1, 32'h002307E1);
    wr(2'd1, 4'b0100, 32'h0001_0000);
    chk("R8 intx falls after clear", {31'b0, intx}, 0);
    @(negedge clk); btn_press = 1; @(negedge clk); btn_press = 0;
    chk("R8 intx rises again", {31'b0, intx}, 1);
    wr(2'd1, 4'b0001, 32'h0000_00C1);
    chk("R8 intx falls with master enable off", {31'b0, intx}, 0);
    wr(2'd1, 4'b0100, 32'h001F_0000);
    @(negedge clk); btn_press = 1; reg_wr = 1; reg_addr = 2'd1; reg_be = 4'b0100;
    reg_wdata = 32'h0001_0000;
    @(negedge clk); btn_press = 0; reg_wr = 0; reg_be = 0;
    rd_chk("R11 set wins over clear", 2'd1, 32'h002107C1);
    @(negedge clk); link_chg = 1; @(negedge clk); link_chg = 0;
    rd_chk("R11 link change status", 2'd1, 32'h003107C1);
    wr(2'd1, 4'b0100, 32'h001F_0000);
  endtask

  task automatic t_message;
    msi_mode = 1;
    wr(2'd1, 4'b0001, 32'h0000_00E1);
    chk("R9 no pulse for disabled command", {31'b0, msg_pulse}, 0);
    @(negedge clk); btn_press = 1; @(negedge clk); btn_press = 0;
    chk("R9 pulse on rise", {31'b0, msg_pulse}, 1);
    chk("R9 intx quiet in message mode", {31'b0, intx}, 0);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'b0, msg_pulse}, 0);
    @(negedge clk); btn_press = 1; @(negedge clk); btn_press = 0;
    chk("R9 no pulse re-setting set event", {31'b0, msg_pulse}, 0);
    wr(2'd1, 4'b0001, 32'h0000_00E9);
    chk("R9 no pulse while condition holds", {31'b0, msg_pulse}, 0);
    wr(2'd1, 4'b0100, 32'h001F_0000);
    @(negedge clk); btn_press = 1; @(negedge clk); btn_press = 0;
    chk("R9 pulse after fall and rise", {31'b0, msg_pulse}, 1);
    msi_mode = 0;
  endtask

  task automatic t_reset_empty;
    do_reset(1'b0);
    rd_chk("R10 R1 reset word1 empty slot", 2'd1, 32'h000007C0);
  endtask

  initial begin
    do_reset(1'b1);
    t_reset_populated;
    t_capability;
    t_command_w1c;
    t_interlock;
    t_detach_add;
    t_intx;
    t_message;
    t_reset_empty;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule